// File: doc/BRIEF.md
# Stretchable Phase-2 Clock Generator

This block takes a single master clock and derives two phase-2 style clocks from it. The first is a steady timebase at the base rate, the master clock divided by `RATIO`. Only a timer peripheral uses it, and nothing ever lengthens it. The second is the system clock for the CPU and its memory. Its high phase can be lengthened one master period at a time, so a slow DRAM access costs only a fraction of a base cycle, not a whole extra cycle.

The system clock also has to meet the timer peripheral in step. When the peripheral-select decode is asserted, and the falling edge of the system clock would not coincide with a falling edge of the timer clock, the high phase keeps stretching until the two edges line up. The next system cycle then begins on a timer-clock rising edge. A registered indicator shows whether the system cycle now running began in step with the timer clock.

Top module: `stretch_clkgen`

## Requirements
- R1: While `rst` is sampled high at a rising master edge, `tmr_clk` and `sys_clk` are driven low and `in_step` is driven high. On the first edge with `rst` low, both clocks rise together.
- R2: `tmr_clk` has a period of exactly `RATIO` master periods. It is high for the first `RATIO/2` of them. `dram_wait` and `tmr_sel` have no effect on it.
- R3: With no stretch, the high phase of `sys_clk` lasts `RATIO/2` master periods.
- R4: At the master edge that would end a high phase of `sys_clk`, a sampled-high `dram_wait` holds `sys_clk` high for one more master period. This repeats on every such edge, so the high phase lasts `RATIO/2` plus the number of stretching edges.
- R5: At that same decision edge, a sampled-high `tmr_sel` holds `sys_clk` high while `tmr_clk` would not fall on that edge. A `sys_clk` fall that ends with `tmr_sel` high therefore coincides with a `tmr_clk` fall. A select that arrives while the clocks are already in step adds no wait.
- R6: The low phase of `sys_clk` always lasts exactly `RATIO/2` master periods.
- R7: `in_step` is updated on each rising edge of `sys_clk`. It is set to 1 if `tmr_clk` rises on the same master edge and to 0 otherwise, and it holds that value until the next `sys_clk` rise.
- R8: The first `sys_clk` cycle after reset is never stretched, whatever `dram_wait` and `tmr_sel` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| dram_wait | input | 1 | Request for one more master period of system-clock high phase |
| tmr_sel | input | 1 | Decode: the current system cycle addresses the timer peripheral |
| tmr_clk | output | 1 | Free-running phase-2 clock for the timer peripheral (registered) |
| sys_clk | output | 1 | Stretchable system phase-2 clock (registered) |
| in_step | output | 1 | The current system cycle began on a `tmr_clk` rising edge (registered) |

## Verification
Every output is a flop, so a request sampled at a master edge appears at the ports after that same edge. The bench drives inputs on the falling master edge. It reads the outputs at the next falling edge, half a period after the rising edge that acted on those inputs. A reference model, advanced on each rising edge from the requirement rules, predicts all three outputs for that comparison. Phase lengths are measured separately by counting falling edges between observed transitions, and each is compared when the phase ends. Because of this, a stretch decided at the would-fall edge is checked in the cycle in which `sys_clk` actually drops.

// File: rtl/stretch_clkgen_pkg.sv
package stretch_clkgen_pkg;
  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } clk_level_e;

  function automatic int half_of(input int ratio);
    return ratio / 2;
  endfunction
endpackage

// File: rtl/ph2_free_div.sv
module ph2_free_div #(
  parameter int RATIO = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tmr_clk,
  output logic fr_rise_nxt,
  output logic fr_fall_nxt
);
  import stretch_clkgen_pkg::*;
  localparam int HALF = half_of(RATIO);
  localparam int FCW  = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [FCW-1:0] LAST_SLOT = FCW'(RATIO - 1);
  localparam logic [FCW-1:0] FALL_SLOT = FCW'(HALF - 1);
  localparam logic [FCW-1:0] HALF_W    = FCW'(HALF);

  logic [FCW-1:0] slot;
  logic [FCW-1:0] slot_nxt;

  always_comb begin
    slot_nxt    = (slot == LAST_SLOT) ? '0 : slot + 1'b1;
    fr_rise_nxt = (slot == LAST_SLOT);
    fr_fall_nxt = (slot == FALL_SLOT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot    <= LAST_SLOT;
      tmr_clk <= LVL_LOW;
    end else begin
      slot    <= slot_nxt;
      tmr_clk <= (slot_nxt < HALF_W);
    end
  end

  // Checker: spacing of timer-clock rising edges
  localparam int GW = FCW + 2;
  logic [GW-1:0] gap;
  logic          tmr_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap   <= GW'(RATIO - 1);
      tmr_d <= 1'b0;
    end else begin
      tmr_d <= tmr_clk;
      if (tmr_clk && !tmr_d) gap <= GW'(1);
      else if (gap != '1)    gap <= gap + 1'b1;
    end
  end

  assert_free_period_R2: assert property (@(posedge clk) disable iff (rst)
    (tmr_clk && !tmr_d) |-> (gap == GW'(RATIO)));
endmodule

// File: rtl/ph2_sys_stretch.sv
module ph2_sys_stretch #(
  parameter int RATIO = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dram_wait,
  input  logic tmr_sel,
  input  logic fr_fall_nxt,
  output logic sys_clk,
  output logic rise_nxt,
  output logic first_cyc
);
  import stretch_clkgen_pkg::*;
  localparam int HALF = half_of(RATIO);
  localparam int SCW  = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [SCW-1:0] LAST = SCW'(HALF - 1);

  clk_level_e     lvl;
  logic [SCW-1:0] slot;
  logic           at_end;
  logic           extend;

  assign sys_clk = (lvl == LVL_HIGH);

  always_comb begin
    at_end   = (slot == LAST);
    rise_nxt = (lvl == LVL_LOW) && at_end;
    extend   = (lvl == LVL_HIGH) && at_end && !first_cyc &&
               (dram_wait || (tmr_sel && !fr_fall_nxt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl       <= LVL_LOW;
      slot      <= LAST;
      first_cyc <= 1'b1;
    end else if (lvl == LVL_LOW) begin
      if (at_end) begin
        lvl  <= LVL_HIGH;
        slot <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end else if (!at_end) begin
      slot <= slot + 1'b1;
    end else if (!extend) begin
      lvl       <= LVL_LOW;
      slot      <= '0;
      first_cyc <= 1'b0;
    end
  end

  // Checker: phase lengths measured independently of slot
  logic [7:0] hi_seen;
  logic [7:0] lo_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_seen <= '0;
      lo_seen <= 8'(HALF - 1);
    end else if (sys_clk) begin
      hi_seen <= (hi_seen == 8'hFF) ? hi_seen : hi_seen + 1'b1;
      lo_seen <= '0;
    end else begin
      lo_seen <= (lo_seen == 8'hFF) ? lo_seen : lo_seen + 1'b1;
      hi_seen <= '0;
    end
  end

  assert_low_len_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_clk) |-> (lo_seen == 8'(HALF)));
  assert_high_min_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_clk) |-> (hi_seen >= 8'(HALF)));
  assert_wait_honored_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_clk) && $past(dram_wait) |-> $past(first_cyc));
  assert_first_short_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_clk) && $past(first_cyc) |-> (hi_seen == 8'(HALF)));
endmodule

// File: rtl/ph2_step_flag.sv
module ph2_step_flag (
  input  logic clk,
  input  logic rst,
  input  logic sys_rise_nxt,
  input  logic fr_rise_nxt,
  output logic in_step
);
  always_ff @(posedge clk) begin
    if (rst)               in_step <= 1'b1;
    else if (sys_rise_nxt) in_step <= fr_rise_nxt;
  end
endmodule

// File: rtl/stretch_clkgen.sv
module stretch_clkgen #(
  parameter int RATIO = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dram_wait,
  input  logic tmr_sel,
  output logic tmr_clk,
  output logic sys_clk,
  output logic in_step
);
  logic fr_rise_nxt;
  logic fr_fall_nxt;
  logic sys_rise_nxt;
  logic first_cyc;

  ph2_free_div #(.RATIO(RATIO)) u_free (
    .clk        (clk),
    .rst        (rst),
    .tmr_clk    (tmr_clk),
    .fr_rise_nxt(fr_rise_nxt),
    .fr_fall_nxt(fr_fall_nxt)
  );

  ph2_sys_stretch #(.RATIO(RATIO)) u_sys (
    .clk        (clk),
    .rst        (rst),
    .dram_wait  (dram_wait),
    .tmr_sel    (tmr_sel),
    .fr_fall_nxt(fr_fall_nxt),
    .sys_clk    (sys_clk),
    .rise_nxt   (sys_rise_nxt),
    .first_cyc  (first_cyc)
  );

  ph2_step_flag u_step (
    .clk         (clk),
    .rst         (rst),
    .sys_rise_nxt(sys_rise_nxt),
    .fr_rise_nxt (fr_rise_nxt),
    .in_step     (in_step)
  );

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sys_clk && !tmr_clk && in_step));
  assert_sel_aligns_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_clk) && $past(tmr_sel) |-> $fell(tmr_clk));
  assert_step_flag_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_clk) |-> (in_step == $rose(tmr_clk)));
endmodule

// File: tb/sim_stretch_clkgen.sv
module sim_stretch_clkgen;
  localparam int CLK_P = 10;
  localparam int RATIO = 2;
  localparam int HALF  = RATIO / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dram_wait = 1'b0;
  logic tmr_sel = 1'b0;
  logic tmr_clk, sys_clk, in_step;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  stretch_clkgen #(.RATIO(RATIO)) u0 (
    .clk(clk), .rst(rst), .dram_wait(dram_wait), .tmr_sel(tmr_sel),
    .tmr_clk(tmr_clk), .sys_clk(sys_clk), .in_step(in_step)
  );

  // Reference model, built from the requirement rules
  int n_edge, m_lo, m_hi, m_waits, m_last_waits;
  bit m_sys, m_first, m_step, m_tmr;

  function automatic bit free_high(input int n);
    return (n > 0) && (((n - 1) % RATIO) < HALF);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      n_edge = 0; m_sys = 0; m_lo = HALF; m_hi = 0;
      m_first = 1; m_step = 1; m_waits = 0; m_last_waits = 0;
    end else begin
      n_edge++;
      if (!m_sys) begin
        if (m_lo >= HALF) begin
          m_sys = 1; m_hi = 1; m_waits = 0;
          m_step = (((n_edge - 1) % RATIO) == 0);
        end else m_lo++;
      end else if (m_hi < HALF) begin
        m_hi++;
      end else if (!m_first &&
                   (dram_wait || (tmr_sel && (((n_edge - 1) % RATIO) != HALF)))) begin
        m_hi++; m_waits++;
      end else begin
        m_sys = 0; m_lo = 1; m_first = 0; m_last_waits = m_waits;
      end
    end
    m_tmr = free_high(n_edge);
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Measurement state
  bit p_sys, p_tmr, fresh_lo, fresh_tmr, first_hi;
  int hi_meas, lo_meas, tmr_gap;

  task automatic cycle(input bit dw, input bit sel);
    @(negedge clk);
    if (!rst) begin
      check("R2 tmr_clk", tmr_clk, m_tmr);
      check("R4 sys_clk", sys_clk, m_sys);
      check("R7 in_step", in_step, m_step);
      if (tmr_clk && !p_tmr) begin
        if (!fresh_tmr) check("R2 period", tmr_gap, RATIO);
        fresh_tmr = 0; tmr_gap = 1;
      end else tmr_gap++;
      if (sys_clk && !p_sys) begin
        if (!fresh_lo) check("R6 low length", lo_meas, HALF);
        fresh_lo = 0; hi_meas = 1;
      end else if (sys_clk) hi_meas++;
      if (!sys_clk && p_sys) begin
        check("R4 high length", hi_meas, HALF + m_last_waits);
        if (first_hi) check("R8 first cycle", hi_meas, HALF);
        if (tmr_sel) check("R5 fall aligned", {p_tmr, tmr_clk}, 2'b10);
        first_hi = 0; lo_meas = 1;
      end else if (!sys_clk) lo_meas++;
      p_sys = sys_clk; p_tmr = tmr_clk;
    end
    dram_wait = dw;
    tmr_sel = sel;
  endtask

  task automatic do_reset(input bit dw, input bit sel);
    @(negedge clk);
    rst = 1; dram_wait = dw; tmr_sel = sel;
    repeat (3) @(negedge clk);
    check("R1 sys low", sys_clk, 0);
    check("R1 tmr low", tmr_clk, 0);
    check("R1 in_step", in_step, 1);
    rst = 0;
    p_sys = 0; p_tmr = 0; fresh_lo = 1; fresh_tmr = 1; first_hi = 1;
    hi_meas = 0; lo_meas = 0; tmr_gap = 0;
    @(posedge clk);
    #1;
    check("R1 both rise", {sys_clk, tmr_clk}, 2'b11);
  endtask

  task automatic random_run(input int cycles);
    for (int i = 0; i < cycles; i++)
      cycle(($urandom % 100) < 30, ($urandom % 100) < 20);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(1234);
    // R8: reset released with both requests held
    do_reset(1, 1);
    for (int i = 0; i < 8; i++) cycle(1, 1);
    // R4: multi-period stretch, then idle
    for (int i = 0; i < 3; i++) cycle(1, 0);
    for (int i = 0; i < 6; i++) cycle(0, 0);
    // R5: misalign with one wait, then select
    for (int k = 0; k < 4; k++) begin
      cycle(1, 0);
      for (int i = 0; i < 3; i++) cycle(0, 0);
      for (int i = 0; i < 4; i++) cycle(0, 1);
      for (int i = 0; i < 4; i++) cycle(0, 0);
    end
    // R5: select while already aligned
    for (int i = 0; i < 8; i++) cycle(0, 1);
    random_run(3000);
    do_reset(0, 0);
    random_run(2000);
    cycle(0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule